// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel with a 16-bit count. A host programs it over an 8-bit bus. Each bus access targets either the shared control-word address or the channel's own data address. The control word selects a channel. For this channel it either takes a snapshot of the count or sets the counting mode. The count is loaded as two byte writes, low byte first. Reads return the count in two byte accesses, again low byte first.

Counting advances on a count-enable strobe that a prescaler outside the block supplies, nominally at 1.19318 MHz. In interrupt-on-terminal-count mode the output rises when the countdown expires and the channel stops. In rate-generator and square-wave modes the channel reloads its stored period at terminal count and leaves the output alone. The block flags any control word it does not support with a one-cycle error pulse and leaves its configuration unchanged.

Top module: `pit_channel`

## Requirements
- R1: After a synchronous active-low reset, `tmr_out` and `cmd_err` are low, the count is zero, the mode is 0, and both byte pointers point at the low byte, so two data reads return 0x00 and then 0x00.
- R2: Control-word fields are select = bits 7:6, format = bits 5:4, mode = bits 3:1 and BCD = bit 0. A word whose select equals `CHAN_ID` acts on this channel. A word with any other select value except 3 is ignored and raises no error.
- R3: `cmd_err` is high for exactly the cycle after the write of an unsupported control word, and the configuration is left unchanged. Unsupported means any of: select 3 (read-back); or, for this channel, format 01 or 10; format 11 with a mode other than 0, 2 or 3; or format 11 with the BCD bit set.
- R4: A data write while the write pointer is on the low byte replaces count bits 7:0, stops counting, drives `tmr_out` low on the next cycle and moves the write pointer to the high byte.
- R5: A data write while the write pointer is on the high byte replaces count bits 15:8, stores the full 16-bit value as the period and returns the write pointer to the low byte. Counting starts only if that value is nonzero; a zero value leaves the channel stopped.
- R6: While running, the count drops by one on each cycle with `cnt_tick` high. While stopped, `cnt_tick` leaves the count unchanged.
- R7: In mode 0, the tick that takes the count from 1 to 0 sets `tmr_out` high on the next cycle and stops the channel with the count held at 0.
- R8: In modes 2 and 3, the tick at count 1 reloads the stored period instead of reaching 0, counting continues, and `tmr_out` keeps its value.
- R9: With no snapshot pending, data reads alternate between the low byte and the high byte of the live count, starting at the low byte. `bus_rdata` is valid in the same cycle as the read strobe.
- R10: A control word with format 00 for this channel copies the count into a snapshot. While the snapshot is pending, reads return the snapshot, and the high-byte read releases it.
- R11: A snapshot command issued while a snapshot is already pending has no effect: the held value and the read pointer stay as they were.
- R12: A snapshot command that is accepted resets the read pointer to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_ctrl | input | 1 | High selects the control-word address, low selects the data address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Data-port read byte, valid during the read strobe |
| cnt_tick | input | 1 | Count-enable strobe from the external prescaler |
| tmr_out | output | 1 | Channel output |
| cmd_err | output | 1 | One-cycle flag for an unsupported control word |

## Verification
`tmr_out` and `cmd_err` come from registers. Each reflects a stimulus one cycle later: an access or tick at clock edge k shows up after edge k+1. `bus_rdata` is combinational from state, so it shows the byte for a read in the same cycle as the strobe, and the pointer moves at the following edge. The bench drives and samples on the falling edge. It compares `tmr_out` and `cmd_err` each cycle against a model state that is updated only after the rising edge has passed, and it checks `bus_rdata` in the cycle of the read strobe against the model's state before that edge.

// File: rtl/pit_pkg.sv
// Shared definitions for the interval counter channel: control-word
// layout, format and mode codes, byte pointer type.
package pit_pkg;

    // Control-word layout: select[7:6], format[5:4], mode[3:1], bcd[0]
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] fmt;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    localparam logic [1:0] SEL_READBACK = 2'b11;
    localparam logic [1:0] FMT_LATCH    = 2'b00;
    localparam logic [1:0] FMT_WORD     = 2'b11;

    localparam logic [2:0] MODE_TC      = 3'd0;  // interrupt on terminal count
    localparam logic [2:0] MODE_RATE    = 3'd2;  // rate generator
    localparam logic [2:0] MODE_SQW     = 3'd3;  // square wave

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

endpackage

// File: rtl/pit_ctrl_decode.sv
// Control-word decoder.
// Purely combinational. Turns a control-address write into a snapshot
// request, a mode update or an error indication for this channel.
// Assumes the caller qualifies ctrl_wr with the write strobe and the
// control address.
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_byte,
    output logic       do_latch,
    output logic       do_mode,
    output logic [2:0] mode_val,
    output logic       bad_cmd
);

    ctrl_word_t cw;
    logic       mode_ok;

    assign cw       = ctrl_word_t'(ctrl_byte);
    assign mode_val = cw.mode;

    // Supported modes are 0, 2 and 3 only
    always_comb begin
        mode_ok = (cw.mode == MODE_TC) || (cw.mode == MODE_RATE) || (cw.mode == MODE_SQW);
    end

    // Classify the control word
    always_comb begin
        do_latch = 1'b0;
        do_mode  = 1'b0;
        bad_cmd  = 1'b0;
        if (ctrl_wr) begin
            if (cw.sel == SEL_READBACK) begin
                bad_cmd = 1'b1;
            end else if (cw.sel == CHAN_ID) begin
                if (cw.fmt == FMT_LATCH) begin
                    do_latch = 1'b1;
                end else if ((cw.fmt != FMT_WORD) || !mode_ok || cw.bcd) begin
                    bad_cmd = 1'b1;
                end else begin
                    do_mode = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pit_count_core.sv
// Count core: holds the live count, the period, the mode, the write
// pointer and the output.
// Assumes at most one bus access per cycle. A data write takes
// priority over a tick in the same cycle.
module pit_count_core
    import pit_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tick,
    input  logic             do_mode,
    input  logic [2:0]       mode_val,
    output logic [CNT_W-1:0] count,
    output logic             out
);

    logic [CNT_W-1:0] period;
    logic [2:0]       mode;
    logic             running;
    byte_ptr_e        wptr;
    logic [CNT_W-1:0] full_val;
    logic             at_term;

    assign full_val = {wdata, count[BUS_W-1:0]};
    assign at_term  = (count == CNT_W'(1));

    // Byte loading, countdown, reload and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            period  <= '0;
            running <= 1'b0;
            out     <= 1'b0;
            wptr    <= PTR_LO;
        end else if (data_wr && (wptr == PTR_LO)) begin
            count[BUS_W-1:0] <= wdata;
            running          <= 1'b0;
            out              <= 1'b0;
            wptr             <= PTR_HI;
        end else if (data_wr) begin
            count[CNT_W-1:BUS_W] <= wdata;
            period               <= full_val;
            running              <= (full_val != '0);
            wptr                 <= PTR_LO;
        end else if (running && tick) begin
            if (at_term) begin
                if (mode == MODE_TC) begin
                    count   <= '0;
                    running <= 1'b0;
                    out     <= 1'b1;
                end else begin
                    count <= period;
                end
            end else begin
                count <= count - CNT_W'(1);
            end
        end
    end

    // Mode register, updated by an accepted mode command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_TC;
        end else if (do_mode) begin
            mode <= mode_val;
        end
    end

    AST_LOW_WR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && wptr == PTR_LO) |=> (!running && !out)); // R4
    AST_ZERO_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && wptr == PTR_HI && full_val == '0) |=> !running); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !data_wr) |=> $stable(count)); // R6
    AST_TC_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && at_term && !data_wr && mode == MODE_TC) |=> (out && !running && count == '0)); // R7
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && at_term && !data_wr && mode != MODE_TC) |=> (count == period && $stable(out) && running)); // R8

endmodule

// File: rtl/pit_read_port.sv
// Read side: the snapshot register, its pending flag, the read pointer
// and the byte multiplexer for the read data.
// Assumes a snapshot request and a data read never arrive in the same
// cycle, since the bus carries one access per cycle.
module pit_read_port
    import pit_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_latch,
    input  logic             data_rd,
    input  logic [CNT_W-1:0] count,
    output logic [BUS_W-1:0] rdata
);

    logic [CNT_W-1:0] snap;
    logic             held;
    byte_ptr_e        rptr;
    logic [CNT_W-1:0] src;

    // Snapshot capture, release and pointer stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
            held <= 1'b0;
            rptr <= PTR_LO;
        end else if (do_latch && !held) begin
            snap <= count;
            held <= 1'b1;
            rptr <= PTR_LO;
        end else if (data_rd) begin
            if (rptr == PTR_LO) begin
                rptr <= PTR_HI;
            end else begin
                rptr <= PTR_LO;
                held <= 1'b0;
            end
        end
    end

    // Pick the byte to present
    always_comb begin
        src   = held ? snap : count;
        rdata = (rptr == PTR_HI) ? src[CNT_W-1:BUS_W] : src[BUS_W-1:0];
    end

    AST_HOLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (held && do_latch) |=> ($stable(snap) && $stable(rptr) && held)); // R11
    AST_HI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && data_rd && rptr == PTR_HI && !do_latch) |=> !held); // R10
    AST_LATCH_PTR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_latch && !held) |=> (rptr == PTR_LO && held)); // R12

endmodule

// File: rtl/pit_channel.sv
// Top level of one interval counter channel.
// Splits bus accesses into control and data traffic, decodes the
// control word, and registers the error flag.
// Assumes bus_wr and bus_rd are never high together. A read of the
// control address has no effect.
module pit_channel
    import pit_pkg::*;
#(
    parameter int         BUS_W   = 8,
    parameter logic [1:0] CHAN_ID = 2'd0,
    localparam int        CNT_W   = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_ctrl,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cnt_tick,
    output logic             tmr_out,
    output logic             cmd_err
);

    logic             ctrl_wr, data_wr, data_rd;
    logic             do_latch, do_mode, bad_cmd;
    logic [2:0]       mode_val;
    logic [CNT_W-1:0] count;

    assign ctrl_wr = bus_wr && bus_ctrl;
    assign data_wr = bus_wr && !bus_ctrl;
    assign data_rd = bus_rd && !bus_ctrl;

    pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .ctrl_wr  (ctrl_wr),
        .ctrl_byte(bus_wdata[7:0]),
        .do_latch (do_latch),
        .do_mode  (do_mode),
        .mode_val (mode_val),
        .bad_cmd  (bad_cmd)
    );

    pit_count_core #(.BUS_W(BUS_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .wdata   (bus_wdata),
        .tick    (cnt_tick),
        .do_mode (do_mode),
        .mode_val(mode_val),
        .count   (count),
        .out     (tmr_out)
    );

    pit_read_port #(.BUS_W(BUS_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_latch(do_latch),
        .data_rd (data_rd),
        .count   (count),
        .rdata   (bus_rdata)
    );

    // One-cycle error flag for a rejected control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= bad_cmd;
        end
    end

    AST_READBACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ctrl && bus_wdata[7:6] == SEL_READBACK) |=> cmd_err); // R3
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> !cmd_err); // R3

endmodule

// File: tb/pit_channel_tb_top.sv
// Self-checking bench for pit_channel: directed corners followed by
// seeded random traffic, all compared against a behavioural model.
module pit_channel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_ctrl = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0;
    logic       tmr_out, cmd_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [15:0] m_count = '0, m_period = '0, m_snap = '0;
    logic [2:0]  m_mode = '0;
    logic        m_run = 0, m_out = 0, m_err = 0, m_held = 0;
    logic        m_wptr = 0, m_rptr = 0;

    always #4 clk = ~clk;

    pit_channel #(.BUS_W(8), .CHAN_ID(2'd0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ctrl(bus_ctrl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .tmr_out(tmr_out), .cmd_err(cmd_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        logic [15:0] s;
        s = m_held ? m_snap : m_count;
        return m_rptr ? s[15:8] : s[7:0];
    endfunction

    // one bus cycle: called at a falling edge, returns at the next one
    task automatic step(input logic wr, input logic rd, input logic ctl,
                        input logic [7:0] d, input logic tk, input string tag);
        logic [15:0] oc;
        logic [2:0]  om;
        logic        err_n;
        check(tag, "tmr_out", int'(tmr_out), int'(m_out));
        check(tag, "cmd_err", int'(cmd_err), int'(m_err));
        bus_wr = wr; bus_rd = rd; bus_ctrl = ctl; bus_wdata = d; cnt_tick = tk;
        #1;
        if (rd && !ctl) check(tag, "rdata", int'(bus_rdata), int'(exp_rdata()));
        oc = m_count; om = m_mode; err_n = 1'b0;
        if (wr && ctl) begin
            if (d[7:6] == 2'b11) err_n = 1'b1;
            else if (d[7:6] == 2'b00) begin
                if (d[5:4] == 2'b00) begin
                    if (!m_held) begin m_held = 1; m_snap = oc; m_rptr = 0; end
                end else if (d[5:4] != 2'b11 || !(d[3:1] == 3'd0 || d[3:1] == 3'd2 || d[3:1] == 3'd3) || d[0])
                    err_n = 1'b1;
                else m_mode = d[3:1];
            end
        end
        if (wr && !ctl) begin
            if (!m_wptr) begin
                m_count[7:0] = d; m_run = 0; m_out = 0; m_wptr = 1;
            end else begin
                m_count[15:8] = d; m_period = m_count; m_run = (m_count != 0); m_wptr = 0;
            end
        end else if (m_run && tk) begin
            if (oc == 16'd1) begin
                if (om == 3'd0) begin m_count = 0; m_run = 0; m_out = 1; end
                else m_count = m_period;
            end else m_count = oc - 16'd1;
        end
        if (rd && !ctl) begin
            if (!m_rptr) m_rptr = 1;
            else begin m_rptr = 0; m_held = 0; end
        end
        @(posedge clk);
        m_err = err_n;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_ctrl = 0; cnt_tick = 0;
    endtask

    task automatic ctrl(input logic [7:0] w, input string tag); step(1, 0, 1, w, 0, tag); endtask
    task automatic wrd(input logic [7:0] b, input string tag);  step(1, 0, 0, b, 0, tag); endtask
    task automatic rdb(input string tag);                      step(0, 1, 0, 8'h00, 0, tag); endtask
    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 1, tag);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rdb("R1"); rdb("R1");
        // R2: mode 2 for this channel; another channel's bad word is ignored
        ctrl(8'b00_11_010_0, "R2");
        ctrl(8'b01_11_001_0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        // R8: period 3 in mode 2 reloads
        wrd(8'h03, "R8"); wrd(8'h00, "R8");
        ticks(4, "R8");
        rdb("R8"); rdb("R8");
        // R3: each unsupported word flags an error, mode kept
        ctrl(8'b11_00_000_0, "R3"); step(0, 0, 0, 0, 0, "R3");
        ctrl(8'b00_01_000_0, "R3"); step(0, 0, 0, 0, 0, "R3");
        ctrl(8'b00_11_001_0, "R3"); step(0, 0, 0, 0, 0, "R3");
        ctrl(8'b00_11_000_1, "R3"); step(0, 0, 0, 0, 0, "R3");
        ticks(3, "R3"); rdb("R3"); rdb("R3");
        // R5: zero value does not arm
        ctrl(8'b00_11_000_0, "R5");
        wrd(8'h00, "R5"); wrd(8'h00, "R5");
        ticks(3, "R5"); rdb("R5"); rdb("R5");
        // R7: mode 0 expiry after 4 ticks
        wrd(8'h04, "R7"); wrd(8'h00, "R7");
        ticks(6, "R7"); rdb("R7"); rdb("R7");
        // R4: low write drops output and halts counting
        wrd(8'h10, "R4");
        ticks(2, "R4"); rdb("R4"); rdb("R4");
        // R6: running countdown
        wrd(8'h01, "R6");
        ticks(5, "R6"); rdb("R6"); rdb("R6");
        // R10 and R11: snapshot held across ticks and a repeated latch
        ctrl(8'b00_00_000_0, "R10");
        ticks(3, "R10");
        rdb("R10");
        ctrl(8'b00_00_000_0, "R11");
        rdb("R11");
        rdb("R10"); rdb("R10");
        // R12: latch with the read pointer on the high byte
        rdb("R9");
        ctrl(8'b00_00_000_0, "R12");
        ticks(2, "R12");
        rdb("R12"); rdb("R12");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int unsigned op;
            logic [7:0]  w;
            op = $urandom % 10;
            if (op == 0) begin
                w = 8'($urandom);
                if ($urandom % 3 != 0) begin
                    case ($urandom % 4)
                        0: w = 8'b00_00_000_0;
                        1: w = 8'b00_11_000_0;
                        2: w = 8'b00_11_010_0;
                        default: w = 8'b00_11_011_0;
                    endcase
                end
                step(1, 0, 1, w, 1'($urandom), "R3");
            end else if (op <= 2) begin
                w = m_wptr ? 8'($urandom % 2) : 8'($urandom);
                step(1, 0, 0, w, 1'($urandom), "R5");
            end else if (op <= 4) begin
                step(0, 1, 0, 8'h00, 1'($urandom), "R9");
            end else begin
                step(0, 0, 0, 8'h00, ($urandom % 5) != 0, "R6");
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule